// File: doc/BRIEF.md
# Interrupt Mask and Serial-Bit Controller

This unit sits beside a processor core and owns the interrupt state the core's control instructions act on: a global interrupt-enable flip-flop, three mask bits for the vectored lines, an edge-latched request for the highest vectored line, and a one-bit serial output latch. A single set-mask write carries several independent fields. Each field is gated by its own enable bit, so one write can update the serial bit, reload the masks and clear the latched request in any combination. A read-mask status word returns the serial input pin, the pending lines, the enable flip-flop and the masks.

Every cycle the unit merges the non-maskable line, the three vectored lines and the general request line into a single request with an encoded source. It also owns the halt state. A halt strobe parks the core, and the core stays parked until a request is issued.

Top module: `icu_ctrl`

## Requirements
- R1: On a set-mask write with bit 6 = 1, `ser_out` takes bit 7 on the next cycle. With bit 6 = 0, `ser_out` holds its value.
- R2: On a set-mask write with bit 3 = 1, the mask bits for the high, middle and low lines load from bits 2, 1 and 0. With bit 3 = 0, the mask bits are unchanged.
- R3: A mask bit of 1 blocks its line from issuing a request. A mask bit of 0 lets the line through.
- R4: A set-mask write with bit 4 = 1 clears the latched high-line request, whatever bit 3 holds.
- R5: Bit 5 of the set-mask word has no effect on any state.
- R6: An EI strobe sets the enable flip-flop. A DI strobe, any `intr_ack`, or reset clears it. When EI arrives in the same cycle as DI or `intr_ack`, the flip-flop is cleared.
- R7: `trap_in` issues request code 0 whatever the enable flip-flop and the masks hold.
- R8: A `halt_req` strobe sets `halted`. `halted` stays set until a cycle in which `irq_valid` is 1, and it is clear on the next cycle. Reset also clears it.
- R9: `rim_data` bit 7 is `ser_in`. Bits 6, 5 and 4 are the pending high, middle and low lines. Bit 3 is the enable flip-flop. Bits 2 to 0 are the masks for the high, middle and low lines. After reset the word reads {ser_in, 0, mid_in, lo_in, 0, 111}.
- R10: A rising edge on `hi_in` sets the latched high-line request, and the request stays set while the line stays high. The middle, low and general lines are level-sensitive.
- R11: Only one request is issued at a time. The source codes, in falling priority, are trap 0, high 1, middle 2, low 3 and general 4. The three vectored lines and the general line need the enable flip-flop set.
- R12: An `intr_ack` while code 1 is issued clears the latched high-line request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sim_we | input | 1 | Set-mask write strobe |
| sim_data | input | 8 | Set-mask command word |
| rim_data | output | 8 | Read-mask status word |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| intr_ack | input | 1 | Acknowledge of the issued request |
| halt_req | input | 1 | Enter-halt strobe |
| halted | output | 1 | Halt state |
| trap_in | input | 1 | Non-maskable request line |
| hi_in | input | 1 | High vectored line, edge-triggered |
| mid_in | input | 1 | Middle vectored line, level |
| lo_in | input | 1 | Low vectored line, level |
| gen_in | input | 1 | General request line, level |
| irq_valid | output | 1 | A request is issued |
| irq_code | output | 3 | Source of the issued request |
| ser_in | input | 1 | Serial input pin |
| ser_out | output | 1 | Serial output latch |

## Verification
The assertions assume that `intr_ack` only arrives while `irq_valid` is high and that strobes are single-cycle pulses. They also assume that `trap_in` is held until it is acknowledged. The bench keeps to these assumptions in three ways. It changes every input only on the falling edge. It pulses acknowledges only after it has seen a request issued. It releases `trap_in` one cycle after it is taken.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int WORD_W  = 8;
  localparam int MASK_W  = 3;
  localparam int SRC_N   = 5;
  localparam int CODE_W  = $clog2(SRC_N);

  // field positions of the set-mask word
  localparam int F_SER_BIT = 7;
  localparam int F_SER_EN  = 6;
  localparam int F_HI_CLR  = 4;
  localparam int F_MASK_EN = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_TRAP = 3'd0,
    SRC_HI   = 3'd1,
    SRC_MID  = 3'd2,
    SRC_LO   = 3'd3,
    SRC_GEN  = 3'd4
  } src_e;

  // keep only the lowest set bit (index 0 is highest priority)
  function automatic logic [SRC_N-1:0] first_set(input logic [SRC_N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
    input logic              sin,
    input logic [MASK_W-1:0] pend,
    input logic              en,
    input logic [MASK_W-1:0] msk);
    return {sin, pend, en, msk};
  endfunction
endpackage

// File: rtl/icu_cfg_regs.sv
module icu_cfg_regs
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ser_bit,
  input  logic              ser_en,
  input  logic              mask_en,
  input  logic [MASK_W-1:0] mask_val,
  input  logic              ei,
  input  logic              di,
  input  logic              ack,
  output logic              ie,
  output logic [MASK_W-1:0] mask,
  output logic              ser_q
);
  logic ie_set, ie_clr;
  assign ie_clr = di | ack;
  assign ie_set = ei & ~ie_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      mask  <= '1;
      ser_q <= 1'b0;
    end else begin
      if (ie_clr)      ie <= 1'b0;
      else if (ie_set) ie <= 1'b1;
      if (wr_en && mask_en) mask  <= mask_val;
      if (wr_en && ser_en)  ser_q <= ser_bit;
    end
  end
endmodule

// File: rtl/icu_edge_req.sv
module icu_edge_req (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic clr,
  output logic pend,
  output logic rise
);
  logic line_q;
  assign rise = line_in & ~line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      line_q <= line_in;
      if (clr)       pend <= 1'b0;
      else if (rise) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
  import icu_pkg::*;
(
  input  logic [SRC_N-1:0]  req,
  output logic [SRC_N-1:0]  grant,
  output logic              valid,
  output logic [CODE_W-1:0] code
);
  assign grant = first_set(req);
  assign valid = |req;

  logic [CODE_W-1:0] enc [SRC_N];
  for (genvar i = 0; i < SRC_N; i++) begin : g_enc
    if (i == 0) begin : g_first
      assign enc[i] = '0;
    end else begin : g_rest
      assign enc[i] = enc[i-1] | (grant[i] ? CODE_W'(i) : '0);
    end
  end
  assign code = enc[SRC_N-1];
endmodule

// File: rtl/icu_ctrl.sv
module icu_ctrl
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sim_we,
  input  logic [WORD_W-1:0] sim_data,
  output logic [WORD_W-1:0] rim_data,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              intr_ack,
  input  logic              halt_req,
  output logic              halted,
  input  logic              trap_in,
  input  logic              hi_in,
  input  logic              mid_in,
  input  logic              lo_in,
  input  logic              gen_in,
  output logic              irq_valid,
  output logic [CODE_W-1:0] irq_code,
  input  logic              ser_in,
  output logic              ser_out
);
  logic              ie;
  logic [MASK_W-1:0] mask;
  logic              hi_pend, hi_rise, hi_clr;
  logic [SRC_N-1:0]  req_vec, grant_vec;

  icu_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(sim_we),
    .ser_bit(sim_data[F_SER_BIT]), .ser_en(sim_data[F_SER_EN]),
    .mask_en(sim_data[F_MASK_EN]), .mask_val(sim_data[MASK_W-1:0]),
    .ei(ei_stb), .di(di_stb), .ack(intr_ack),
    .ie(ie), .mask(mask), .ser_q(ser_out)
  );

  assign hi_clr = (sim_we & sim_data[F_HI_CLR]) |
                  (intr_ack & irq_valid & (irq_code == SRC_HI));

  icu_edge_req u_hi (
    .clk(clk), .rst_n(rst_n), .line_in(hi_in), .clr(hi_clr),
    .pend(hi_pend), .rise(hi_rise)
  );

  // mask[2]=high, mask[1]=middle, mask[0]=low
  assign req_vec[SRC_TRAP] = trap_in;
  assign req_vec[SRC_HI]   = ie & ~mask[2] & hi_pend;
  assign req_vec[SRC_MID]  = ie & ~mask[1] & mid_in;
  assign req_vec[SRC_LO]   = ie & ~mask[0] & lo_in;
  assign req_vec[SRC_GEN]  = ie & gen_in;

  icu_arbiter u_arb (
    .req(req_vec), .grant(grant_vec), .valid(irq_valid), .code(irq_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         halted <= 1'b0;
    else if (irq_valid) halted <= 1'b0;
    else if (halt_req)  halted <= 1'b1;
  end

  assign rim_data = pack_status(ser_in, {hi_pend, mid_in, lo_in}, ie, mask);
endmodule

// File: rtl/icu_ctrl_chk.sv
module icu_ctrl_chk
  import icu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sim_we,
  input logic [WORD_W-1:0] sim_data,
  input logic [WORD_W-1:0] rim_data,
  input logic              intr_ack,
  input logic              di_stb,
  input logic              trap_in,
  input logic              irq_valid,
  input logic [CODE_W-1:0] irq_code,
  input logic              halted,
  input logic              ser_out,
  input logic              hi_rise,
  input logic [SRC_N-1:0]  grant_vec
);
  p_ser_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sim_we && !sim_data[6] |=> $stable(ser_out));
  p_ser_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sim_we && sim_data[6] |=> ser_out == $past(sim_data[7]));
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sim_we && !sim_data[3] |=> $stable(rim_data[2:0]));
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sim_we && sim_data[3] |=> rim_data[2:0] == $past(sim_data[2:0]));
  p_hi_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sim_we && sim_data[4] |=> !rim_data[6]);
  p_spare_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sim_we && sim_data[5] && !sim_data[3] |=> $stable(rim_data[2:0]));
  p_ie_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_ack || di_stb) |=> !rim_data[3]);
  p_trap_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |-> irq_valid && irq_code == SRC_TRAP);
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !irq_valid |=> halted);
  p_halt_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !halted);
  p_edge_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rise && !(sim_we && sim_data[4]) && !intr_ack |=> rim_data[6]);
  p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && (irq_valid == (grant_vec != '0)));
endmodule

bind icu_ctrl icu_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sim_we(sim_we), .sim_data(sim_data),
  .rim_data(rim_data), .intr_ack(intr_ack), .di_stb(di_stb),
  .trap_in(trap_in), .irq_valid(irq_valid), .irq_code(irq_code),
  .halted(halted), .ser_out(ser_out), .hi_rise(hi_rise),
  .grant_vec(grant_vec)
);

// File: tb/icu_ctrl_bench.sv
module icu_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, sim_we, ei_stb, di_stb, intr_ack, halt_req;
  logic       trap_in, hi_in, mid_in, lo_in, gen_in, ser_in;
  logic [7:0] sim_data, rim_data;
  logic       halted, irq_valid, ser_out;
  logic [2:0] irq_code;

  icu_ctrl u_icu_ctrl (
    .clk(clk), .rst_n(rst_n), .sim_we(sim_we), .sim_data(sim_data),
    .rim_data(rim_data), .ei_stb(ei_stb), .di_stb(di_stb),
    .intr_ack(intr_ack), .halt_req(halt_req), .halted(halted),
    .trap_in(trap_in), .hi_in(hi_in), .mid_in(mid_in), .lo_in(lo_in),
    .gen_in(gen_in), .irq_valid(irq_valid), .irq_code(irq_code),
    .ser_in(ser_in), .ser_out(ser_out)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // {command word, expected ser_out, expected masks}
  localparam logic [11:0] VEC [8] = '{
    {8'h08, 1'b0, 3'b000},
    {8'hC0, 1'b1, 3'b000},
    {8'h80, 1'b1, 3'b000},
    {8'h0D, 1'b1, 3'b101},
    {8'h07, 1'b1, 3'b101},
    {8'h40, 1'b0, 3'b101},
    {8'h2A, 1'b0, 3'b010},
    {8'hCF, 1'b1, 3'b111}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sim_write(input logic [7:0] d);
    sim_we = 1'b1; sim_data = d; tick(); sim_we = 1'b0; sim_data = 8'h00;
  endtask

  task automatic pulse_ei(input logic e, input logic d);
    ei_stb = e; di_stb = d; tick(); ei_stb = 1'b0; di_stb = 1'b0;
  endtask

  task automatic chk_irq(input string tag, input logic v, input logic [2:0] c);
    check(tag, {4'd0, irq_valid, irq_code}, {4'd0, v, v ? c : irq_code});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sim_we = 0; sim_data = 0; ei_stb = 0; di_stb = 0; intr_ack = 0;
    halt_req = 0; trap_in = 0; hi_in = 0; mid_in = 0; lo_in = 0; gen_in = 0; ser_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    check("R9 reset status", rim_data, 8'h07);
    check("R6 reset outputs", {5'd0, ser_out, irq_valid, halted}, 8'h00);

    // R1/R2 table walk
    for (int i = 0; i < 8; i++) begin
      sim_write(VEC[i][11:4]);
      check("R1 serial latch", {7'd0, ser_out}, {7'd0, VEC[i][3]});
      check("R2 mask load", {5'd0, rim_data[2:0]}, {5'd0, VEC[i][2:0]});
    end

    // R5: spare bit alone changes nothing
    sim_write(8'h20);
    check("R5 spare bit", {ser_out, rim_data[6:0]}, {1'b1, 7'h07});

    // R6 enable flip-flop
    pulse_ei(1, 0); check("R6 EI sets", {7'd0, rim_data[3]}, 8'd1);
    pulse_ei(1, 1); check("R6 DI wins over EI", {7'd0, rim_data[3]}, 8'd0);
    pulse_ei(1, 0); pulse_ei(0, 1);
    check("R6 DI clears", {7'd0, rim_data[3]}, 8'd0);
    pulse_ei(1, 0);
    sim_write(8'h08);
    check("R9 status layout", rim_data, 8'h08);

    // R11 priority among level lines
    mid_in = 1; lo_in = 1; gen_in = 1; tick();
    chk_irq("R11 middle wins", 1, 3'd2);
    check("R9 pending levels", {6'd0, rim_data[5:4]}, 8'h03);
    mid_in = 0; tick(); chk_irq("R11 low next", 1, 3'd3);
    lo_in = 0; tick(); chk_irq("R11 general last", 1, 3'd4);
    gen_in = 0; tick(); chk_irq("R11 idle", 0, 3'd0);

    // R3 mask polarity
    sim_write(8'h09); lo_in = 1; tick();
    chk_irq("R3 masked line blocked", 0, 3'd0);
    check("R3 pending still visible", {7'd0, rim_data[4]}, 8'd1);
    sim_write(8'h08);
    chk_irq("R3 unmasked line issues", 1, 3'd3);
    lo_in = 0;

    // R10 / R12 edge latch and acknowledge
    hi_in = 1; tick();
    check("R10 edge latched", {7'd0, rim_data[6]}, 8'd1);
    chk_irq("R11 high issued", 1, 3'd1);
    intr_ack = 1; tick(); intr_ack = 0;
    check("R12 ack clears high", {7'd0, rim_data[6]}, 8'd0);
    check("R6 ack clears enable", {7'd0, rim_data[3]}, 8'd0);
    tick(); tick();
    check("R10 no retrigger while high", {7'd0, rim_data[6]}, 8'd0);

    // R4 clear via command word without mask-set-enable
    hi_in = 0; tick(); hi_in = 1; tick();
    check("R10 new edge", {7'd0, rim_data[6]}, 8'd1);
    sim_write(8'h10);
    check("R4 clear request", {rim_data[6], 4'd0, rim_data[2:0]}, 8'h00);
    hi_in = 0;

    // R7 trap bypasses enable and masks
    sim_write(8'h0F); trap_in = 1; tick();
    chk_irq("R7 trap bypass", 1, 3'd0);
    trap_in = 0; tick();

    // R8 halt
    lo_in = 1;
    halt_req = 1; tick(); halt_req = 0;
    check("R8 halted", {7'd0, halted}, 8'd1);
    tick(); tick();
    check("R8 masked line keeps halt", {7'd0, halted}, 8'd1);
    lo_in = 0; trap_in = 1; tick(); trap_in = 0;
    check("R8 released", {7'd0, halted}, 8'd0);

    // R9 serial input bit
    ser_in = 1; tick();
    check("R9 serial in", {7'd0, rim_data[7]}, 8'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule